// File: doc/BRIEF.md
# Interrupt Acknowledge Unit

This block is the acknowledge path for each processor of a multiprocessor interrupt controller. Every processor has a set of raised sources, filled from the `raise_req` input, and an interrupt output line. When a processor reads its acknowledge register, the block performs several steps in one clock edge:

- It drops that processor's interrupt line.
- It picks the best raised source.
- It checks that source against its activity flag and against the processor's task priority.
- On success it moves the source into the processor's in-service set and returns its vector. On failure it returns the spurious vector.

Source configuration belongs to the surrounding controller and comes in on flat input vectors. Changes the acknowledge makes to that configuration leave the block as a one-cycle update record. The record covers the activity flag, the pending flag and the destination mask.

Inter-processor sources need extra handling. The acknowledging processor is dropped from the destination mask. If an edge-triggered inter-processor source still has other destinations, the block raises it again for those processors. It also asks for the activity flag to be set again, so the source stays live until every target has taken it.

Top module: `irq_ack_unit`

## Requirements
- R1: A read at offset 0xA0 (`rd_addr[11:0]`) is an acknowledge by the processor whose index is in `rd_addr[16:12]`. `rd_data` and the `upd_*` record appear on the clock after the read strobe. `rd_data` holds its value when there is no read.
- R2: Raising any source for a processor sets its `irq_out` bit. An acknowledge by that processor clears the bit on the same edge. A raise in the same cycle as the acknowledge wins, and the line stays high.
- R3: An acknowledge with an empty raised set returns the spurious vector, zero-extended, and changes no state.
- R4: The chosen source is the raised source with the highest priority. Ties go to the lowest source index.
- R5: If the chosen source's activity flag is 0, or its priority is not strictly above the processor's task priority, the read returns the spurious vector. The update record then has `upd_act_we`=1 and `upd_act_val`=0.
- R6: Otherwise the source's bit (index cpu*N_SRC+src) is set in `in_service`, and the read returns the source's vector, zero-extended.
- R7: The chosen source is removed from the raised set whether it is accepted or rejected, unless a raise of the same bit arrives in that cycle.
- R8: For an edge source (level flag 0), the update record has `upd_pend_clr`=1 and `upd_act_we`=1. `upd_valid`=1 whenever a source was chosen, and `upd_src` gives the source index.
- R9: For a source with index from IPI_BASE to IPI_BASE+N_IPI-1, `upd_dest_we`=1 and `upd_dest_val` is the destination mask with the acknowledger's bit cleared. If that mask is non-zero and the source is an edge source, the source is re-raised, with `irq_out` set, for each remaining processor, and `upd_act_val`=1.
- R10: A read at any other offset, or with a processor index of N_CPU or above, returns all ones and changes no state.
- R11: After reset, all sets, interrupt lines, `rd_data` and the update record are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 17 | Read address: processor index in bits 16:12, offset in bits 11:0 |
| rd_data | output | DW | Registered read data |
| raise_req | input | N_CPU*N_SRC | Raise pulses; bit cpu*N_SRC+src |
| src_prio | input | N_SRC*PRIO_W | Priority of each source |
| src_vec | input | N_SRC*VEC_W | Vector of each source |
| src_active | input | N_SRC | Activity flag of each source |
| src_level | input | N_SRC | 1 = level-sensitive, 0 = edge |
| src_dest | input | N_SRC*N_CPU | Destination mask of each source |
| task_prio | input | N_CPU*PRIO_W | Task priority of each processor |
| spur_vec | input | VEC_W | Spurious vector value |
| irq_out | output | N_CPU | Interrupt line of each processor |
| raised | output | N_CPU*N_SRC | Raised sets |
| in_service | output | N_CPU*N_SRC | In-service sets |
| upd_valid | output | 1 | An acknowledge chose a source last cycle |
| upd_src | output | SW | Index of that source |
| upd_act_we | output | 1 | Write the activity flag |
| upd_act_val | output | 1 | New activity flag value |
| upd_pend_clr | output | 1 | Clear the pending flag |
| upd_dest_we | output | 1 | Write the destination mask |
| upd_dest_val | output | N_CPU | New destination mask |

## Verification
An external raise and an acknowledge can land in the same cycle. Both may act on the same processor's interrupt line and on the same raised bit. The re-raise of an inter-processor source can also coincide with a fresh raise for another processor. The bench provokes these cases by pulsing `raise_req` on exactly the edge of an acknowledge read, both in directed cases and in a long random phase. A behavioural model applies the clear first and the raise second, and `irq_out`, `raised`, `in_service`, `rd_data` and the update record are compared against it on every clock.

// File: rtl/irq_ack_unit.sv
module irq_ack_unit #(
  parameter int N_SRC    = 32,
  parameter int N_CPU    = 4,
  parameter int PRIO_W   = 4,
  parameter int VEC_W    = 16,
  parameter int DW       = 32,
  parameter int IPI_BASE = 28,
  parameter int N_IPI    = 4,
  localparam int SW      = $clog2(N_SRC),
  localparam int CW      = (N_CPU > 1) ? $clog2(N_CPU) : 1,
  localparam int NB      = N_CPU * N_SRC
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_en,
  input  logic [16:0]             rd_addr,
  output logic [DW-1:0]           rd_data,
  input  logic [NB-1:0]           raise_req,
  input  logic [N_SRC*PRIO_W-1:0] src_prio,
  input  logic [N_SRC*VEC_W-1:0]  src_vec,
  input  logic [N_SRC-1:0]        src_active,
  input  logic [N_SRC-1:0]        src_level,
  input  logic [N_SRC*N_CPU-1:0]  src_dest,
  input  logic [N_CPU*PRIO_W-1:0] task_prio,
  input  logic [VEC_W-1:0]        spur_vec,
  output logic [N_CPU-1:0]        irq_out,
  output logic [NB-1:0]           raised,
  output logic [NB-1:0]           in_service,
  output logic                    upd_valid,
  output logic [SW-1:0]           upd_src,
  output logic                    upd_act_we,
  output logic                    upd_act_val,
  output logic                    upd_pend_clr,
  output logic                    upd_dest_we,
  output logic [N_CPU-1:0]        upd_dest_val
);
  localparam logic [11:0] ACK_OFS = 12'hA0;

  logic [4:0]        cpu_sel;
  logic [CW-1:0]     cpu;
  logic              ack;
  logic              found;
  logic [SW-1:0]     best;
  logic [PRIO_W-1:0] bprio;
  logic              ok, is_edge, is_ipi, retrig;
  logic [N_CPU-1:0]  cbit, rem;
  logic [NB-1:0]     raised_d, insvc_d;
  logic [N_CPU-1:0]  irq_d;
  logic [DW-1:0]     rd_d;
  int                base;

  assign cpu_sel = rd_addr[16:12];
  assign cpu     = cpu_sel[CW-1:0];
  assign ack     = rd_en && rd_addr[11:0] == ACK_OFS && {1'b0, cpu_sel} < 6'(N_CPU);
  assign base    = int'(cpu) * N_SRC;

  always_comb begin
    found = 1'b0;
    best  = '0;
    bprio = '0;
    for (int s = 0; s < N_SRC; s++) begin
      if (raised[base + s] && (!found || src_prio[s*PRIO_W +: PRIO_W] > bprio)) begin
        found = 1'b1;
        best  = SW'(s);
        bprio = src_prio[s*PRIO_W +: PRIO_W];
      end
    end
  end

  assign ok      = src_active[best] && bprio > task_prio[int'(cpu)*PRIO_W +: PRIO_W];
  assign is_edge = !src_level[best];
  assign is_ipi  = int'(best) >= IPI_BASE && int'(best) < IPI_BASE + N_IPI;

  always_comb begin
    cbit      = '0;
    cbit[cpu] = 1'b1;
  end

  assign rem    = src_dest[int'(best)*N_CPU +: N_CPU] & ~cbit;
  assign retrig = ack && found && is_ipi && is_edge && |rem;

  always_comb begin
    raised_d = raised;
    insvc_d  = in_service;
    if (ack && found) begin
      raised_d[base + int'(best)] = 1'b0;
      if (ok) insvc_d[base + int'(best)] = 1'b1;
    end
    for (int c = 0; c < N_CPU; c++) begin
      if (retrig && rem[c]) raised_d[c*N_SRC + int'(best)] = 1'b1;
      irq_d[c] = (irq_out[c] && !(ack && cpu == CW'(c))) ||
                 |raise_req[c*N_SRC +: N_SRC] || (retrig && rem[c]);
    end
    raised_d = raised_d | raise_req;
  end

  always_comb begin
    rd_d = rd_data;
    if (ack)
      rd_d = {{(DW-VEC_W){1'b0}}, (found && ok) ? src_vec[int'(best)*VEC_W +: VEC_W] : spur_vec};
    else if (rd_en)
      rd_d = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data      <= '0;
      irq_out      <= '0;
      raised       <= '0;
      in_service   <= '0;
      upd_valid    <= 1'b0;
      upd_src      <= '0;
      upd_act_we   <= 1'b0;
      upd_act_val  <= 1'b0;
      upd_pend_clr <= 1'b0;
      upd_dest_we  <= 1'b0;
      upd_dest_val <= '0;
    end else begin
      rd_data      <= rd_d;
      irq_out      <= irq_d;
      raised       <= raised_d;
      in_service   <= insvc_d;
      upd_valid    <= ack && found;
      upd_src      <= (ack && found) ? best : '0;
      upd_act_we   <= ack && found && (!ok || is_edge);
      upd_act_val  <= retrig;
      upd_pend_clr <= ack && found && is_edge;
      upd_dest_we  <= ack && found && is_ipi;
      upd_dest_val <= (ack && found && is_ipi) ? rem : '0;
    end
  end
endmodule

module irq_ack_unit_chk #(
  parameter int N_SRC = 32,
  parameter int N_CPU = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   rd_en,
  input logic [16:0]            rd_addr,
  input logic [31:0]            rd_data,
  input logic [N_CPU*N_SRC-1:0] raise_req,
  input logic [N_CPU-1:0]       irq_out,
  input logic [N_CPU*N_SRC-1:0] in_service,
  input logic                   upd_valid,
  input logic                   upd_act_we,
  input logic                   upd_act_val,
  input logic                   upd_pend_clr,
  input logic                   upd_dest_we,
  input logic [N_CPU-1:0]       upd_dest_val
);
  logic [N_CPU-1:0] drop;
  logic             mapped;

  assign mapped = rd_addr[11:0] == 12'hA0 && {1'b0, rd_addr[16:12]} < 6'(N_CPU);

  always_comb
    for (int c = 0; c < N_CPU; c++)
      drop[c] = rd_en && mapped && rd_addr[16:12] == 5'(c) && !(|raise_req[c*N_SRC +: N_SRC]);

  assert_unmapped_ones_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !mapped |=> rd_data == 32'hFFFF_FFFF);
  assert_insvc_grows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (in_service & $past(in_service)) == $past(in_service));
  assert_irq_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    |drop |=> (irq_out & $past(drop)) == '0);
  assert_upd_follows_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> $past(rd_en));
  assert_edge_writes_act_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pend_clr |-> upd_valid && upd_act_we);
  assert_reraise_has_dest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_act_val |-> upd_dest_we && |upd_dest_val && upd_pend_clr);
endmodule

bind irq_ack_unit irq_ack_unit_chk #(.N_SRC(N_SRC), .N_CPU(N_CPU)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data[31:0]),
  .raise_req(raise_req), .irq_out(irq_out), .in_service(in_service),
  .upd_valid(upd_valid), .upd_act_we(upd_act_we), .upd_act_val(upd_act_val),
  .upd_pend_clr(upd_pend_clr), .upd_dest_we(upd_dest_we), .upd_dest_val(upd_dest_val)
);

// File: tb/irq_ack_unit_tb.sv
module irq_ack_unit_tb_top;
  localparam int NS = 32, NC = 4, PW = 4, VW = 16, NB = NS * NC;
  localparam logic [15:0] SPUR = 16'h00FF;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic            rd_en = 1'b0;
  logic [16:0]     rd_addr = '0;
  logic [NB-1:0]   raise_req = '0;
  logic [PW-1:0]   prio [NS];
  logic [VW-1:0]   vec [NS];
  logic            act [NS];
  logic            lvl [NS];
  logic [NC-1:0]   dst [NS];
  logic [PW-1:0]   tp [NC];
  logic [NS*PW-1:0] src_prio;
  logic [NS*VW-1:0] src_vec;
  logic [NS-1:0]   src_active, src_level;
  logic [NS*NC-1:0] src_dest;
  logic [NC*PW-1:0] task_prio;

  always_comb
    for (int s = 0; s < NS; s++) begin
      src_prio[s*PW +: PW] = prio[s];
      src_vec[s*VW +: VW]  = vec[s];
      src_active[s]        = act[s];
      src_level[s]         = lvl[s];
      src_dest[s*NC +: NC] = dst[s];
    end
  always_comb for (int c = 0; c < NC; c++) task_prio[c*PW +: PW] = tp[c];

  logic [31:0]   rd_data;
  logic [NC-1:0] irq_out, upd_dest_val;
  logic [NB-1:0] raised, in_service;
  logic          upd_valid, upd_act_we, upd_act_val, upd_pend_clr, upd_dest_we;
  logic [4:0]    upd_src;

  irq_ack_unit dut_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .raise_req(raise_req), .src_prio(src_prio), .src_vec(src_vec), .src_active(src_active),
    .src_level(src_level), .src_dest(src_dest), .task_prio(task_prio), .spur_vec(SPUR),
    .irq_out(irq_out), .raised(raised), .in_service(in_service), .upd_valid(upd_valid),
    .upd_src(upd_src), .upd_act_we(upd_act_we), .upd_act_val(upd_act_val),
    .upd_pend_clr(upd_pend_clr), .upd_dest_we(upd_dest_we), .upd_dest_val(upd_dest_val)
  );

  int checks = 0, errors = 0;

  task automatic chk(string tag, logic [NB-1:0] got, logic [NB-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [NB-1:0] m_raised, m_insvc;
  logic [NC-1:0] m_irq, e_dval;
  logic [31:0]   e_rd;
  logic          e_valid, e_awe, e_aval, e_pclr, e_dwe;
  int            e_src;
  string         e_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_raised = '0; m_insvc = '0; m_irq = '0; e_rd = '0; e_tag = "R11 reset";
      e_valid = 0; e_awe = 0; e_aval = 0; e_pclr = 0; e_dwe = 0; e_dval = '0; e_src = 0;
    end else begin
      e_valid = 0; e_awe = 0; e_aval = 0; e_pclr = 0; e_dwe = 0; e_dval = '0; e_src = 0;
      e_tag = "R1 hold";
      if (rd_en) begin
        int c;
        c = int'(rd_addr[16:12]);
        if (rd_addr[11:0] == 12'hA0 && c < NC) begin
          int b;
          b = -1;
          m_irq[c] = 1'b0;
          for (int s = 0; s < NS; s++)
            if (m_raised[c*NS+s] && (b < 0 || prio[s] > prio[b])) b = s;
          if (b < 0) begin
            e_rd = {16'h0, SPUR}; e_tag = "R3 empty";
          end else begin
            logic [NC-1:0] left;
            bit good, edge_s, ipi;
            good   = act[b] && prio[b] > tp[c];
            edge_s = !lvl[b];
            ipi    = b >= 28;
            m_raised[c*NS+b] = 1'b0;
            if (good) begin
              m_insvc[c*NS+b] = 1'b1; e_rd = {16'h0, vec[b]}; e_tag = "R4 R6 accept";
            end else begin
              e_rd = {16'h0, SPUR}; e_tag = "R5 reject";
            end
            left = dst[b];
            left[c] = 1'b0;
            e_valid = 1; e_src = b; e_awe = !good || edge_s; e_pclr = edge_s;
            if (ipi) begin
              e_dwe = 1; e_dval = left;
              if (edge_s && left != 0) begin
                e_aval = 1;
                for (int d = 0; d < NC; d++)
                  if (left[d]) begin m_raised[d*NS+b] = 1'b1; m_irq[d] = 1'b1; end
              end
            end
          end
        end else begin
          e_rd = 32'hFFFF_FFFF; e_tag = "R10 unmapped";
        end
      end
      for (int i = 0; i < NB; i++)
        if (raise_req[i]) begin m_raised[i] = 1'b1; m_irq[i/NS] = 1'b1; end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(e_tag, NB'(rd_data), NB'(e_rd));
    chk("R2 irq", NB'(irq_out), NB'(m_irq));
    chk("R7 raised", raised, m_raised);
    chk("R6 in_service", in_service, m_insvc);
    chk("R8 upd", NB'({upd_valid, upd_src, upd_act_we, upd_pend_clr}),
        NB'({e_valid, 5'(e_src), e_awe, e_pclr}));
    chk("R9 upd", NB'({upd_dest_we, upd_dest_val, upd_act_val}), NB'({e_dwe, e_dval, e_aval}));
  end

  task automatic cyc(bit r, int cpu, logic [11:0] ofs, logic [NB-1:0] rq);
    @(negedge clk);
    rd_en = r; rd_addr = {5'(cpu), ofs}; raise_req = rq;
    @(negedge clk);
    rd_en = 0; raise_req = '0;
  endtask

  function automatic logic [NB-1:0] bitv(int c, int s);
    logic [NB-1:0] v = '0;
    v[c*NS+s] = 1'b1;
    return v;
  endfunction

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    for (int s = 0; s < NS; s++) begin
      prio[s] = PW'((s * 7) % 16); vec[s] = 16'h1000 + 16'(s); act[s] = 1;
      lvl[s] = s < 16; dst[s] = (s >= 28) ? 4'b1111 : 4'b0001;
    end
    for (int c = 0; c < NC; c++) tp[c] = '0;
    repeat (3) @(negedge clk);
    chk("R11 reset rd", NB'(rd_data), '0);
    chk("R11 reset sets", raised | in_service, '0);
    chk("R11 reset irq", NB'({irq_out, upd_valid}), '0);
    rst_n = 1;
    cyc(1, 0, 12'hA0, '0);                       // R3 empty
    chk("R3 spurious", NB'(rd_data), NB'(SPUR));
    prio[3] = 9; prio[5] = 9; prio[9] = 2;
    cyc(0, 0, 0, bitv(1, 5) | bitv(1, 3) | bitv(1, 9));
    chk("R2 irq set", NB'(irq_out[1]), 1);
    cyc(1, 1, 12'hA0, '0);                       // R4 tie -> 3
    chk("R4 tie lowest", NB'(rd_data), NB'(16'h1003));
    cyc(1, 1, 12'hA0, '0);
    chk("R4 next 5", NB'(rd_data), NB'(16'h1005));
    tp[2] = 4'd10; prio[6] = 10;
    cyc(0, 0, 0, bitv(2, 6));
    cyc(1, 2, 12'hA0, '0);
    chk("R5 equal prio rejected", NB'(rd_data), NB'(SPUR));
    chk("R7 removed on reject", NB'(raised[2*NS+6]), 0);
    act[7] = 0; prio[7] = 12;
    cyc(0, 0, 0, bitv(3, 7));
    cyc(1, 3, 12'hA0, '0);
    chk("R5 inactive", NB'({rd_data[15:0], upd_act_we, upd_act_val}), NB'({SPUR, 2'b10}));
    cyc(1, 0, 12'hB0, '0);
    chk("R10 other offset", NB'(rd_data), NB'(32'hFFFF_FFFF));
    cyc(0, 0, 0, bitv(0, 20));
    cyc(1, 5, 12'hA0, '0);
    chk("R10 no state change", NB'({rd_data, raised[20]}), NB'({32'hFFFF_FFFF, 1'b1}));
    cyc(1, 0, 12'hA0, bitv(0, 20));             // R2 raise wins same cycle
    chk("R2 R7 raise wins", NB'({irq_out[0], raised[20], in_service[20]}), NB'(3'b111));
    cyc(1, 0, 12'hA0, '0);
    chk("R8 edge update", NB'({upd_pend_clr, upd_act_we, upd_src}), NB'({2'b11, 5'd20}));
    cyc(0, 0, 0, bitv(0, 29));
    cyc(1, 0, 12'hA0, '0);                       // R9 IPI re-raise
    chk("R9 dest", NB'({upd_dest_we, upd_dest_val, upd_act_val}), NB'({1'b1, 4'b1110, 1'b1}));
    chk("R9 re-raised", NB'({raised[1*NS+29], raised[3*NS+29], irq_out[3:1]}), NB'(5'b11111));
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (k % 50 == 0)
        for (int s = 0; s < NS; s++) begin
          prio[s] = PW'($urandom); act[s] = ($urandom % 4) != 0; lvl[s] = $urandom % 2;
          dst[s] = NC'($urandom);
        end
      if (k % 97 == 0) for (int c = 0; c < NC; c++) tp[c] = PW'($urandom % 8);
      rd_en = ($urandom % 3) == 0;
      rd_addr = {5'($urandom % 6), ($urandom % 8 == 0) ? 12'hB0 : 12'hA0};
      raise_req = '0;
      if ($urandom % 2 == 0) raise_req[$urandom % NB] = 1'b1;
      if ($urandom % 4 == 0) raise_req[$urandom % NB] = 1'b1;
    end
    @(negedge clk);
    rd_en = 0; raise_req = '0;
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule